// File: doc/BRIEF.md
# Parallel SAR Converter Bus Front End

This block is the digital control and output side of a 16-bit successive-approximation converter that reports its results over a parallel bus. It watches an active-low convert strobe that is qualified by chip select. When a start is accepted, it captures the word on a sample input port and raises a busy flag for a fixed number of clock cycles. At the end of that period it moves the captured word into an output latch. The analog side is not part of the block: the sample port stands in for the comparator result, and all timing is counted in cycles of the system clock.

A host reads the latched word by pulling chip select and read low together. With the byte select input low the whole word appears on the bus. With byte select high the low half is folded onto the upper lane and the lower lane is driven all ones, so an 8-bit host can fetch the result in two reads. A separate acquire flag shows when the converter would be tracking its input. An asynchronous active-low reset aborts any conversion and clears the latch.

Top module: `sar_bus_front`

## Requirements
- R1: A start is accepted when `conv_n` has a high-to-low change and `cs_n` is low at that clock sample, and `conv_n` then stays low for MIN_LOW consecutive clock samples, counting the first one. `busy` rises just after the MIN_LOW-th such rising clock edge.
- R2: A falling `conv_n` seen while `cs_n` is high starts nothing: `busy` stays low and the latched result is unchanged.
- R3: A `conv_n` low pulse shorter than MIN_LOW samples starts nothing and leaves the latched result unchanged.
- R4: Once high, `busy` stays high for exactly CONV_CYC clock cycles and then falls.
- R5: Falling `conv_n` edges that arrive while a start is pending or `busy` is high are ignored. They neither restart the conversion nor replace the captured sample.
- R6: `sample_in` is captured at the clock edge that sees the accepted `conv_n` fall. The captured word is copied to the output latch at the edge where `busy` falls, and the latch changes at no other time except reset.
- R7: `db_drive` is 1 and `db` is driven only while `cs_n` and `rd_n` are both low. Otherwise `db_drive` is 0 and `db` is high-impedance.
- R8: With `byte_sel` = 0, a read gives the latched 16-bit two's complement word unchanged on `db[15:0]`. This includes the extreme codes 16'h7FFF, 16'h8000 and midscale 16'h0000.
- R9: With `byte_sel` = 1, `db[15:8]` carries latch bits [7:0] and `db[7:0]` is 8'hFF.
- R10: While `rst_n` is low, `busy` and `acq` are 0 and the latch reads 16'h0000, whatever the state of `cs_n`. Asserting reset aborts a running conversion at once.
- R11: After `rst_n` rises, `acq` goes high after RST_DLY+2 clock edges: two edges of reset synchronisation plus RST_DLY edges of delay. It does this without any chip-select activity.
- R12: `acq` is 0 on the edge after `busy` is high. Outside the first period after reset, `acq` rises one edge after the later of the `busy` fall and the `cs_n` fall, provided `cs_n` is low and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| conv_n | input | 1 | Active-low convert strobe; the falling change requests a start |
| cs_n | input | 1 | Active-low chip select; qualifies starts and reads |
| rd_n | input | 1 | Active-low read strobe |
| byte_sel | input | 1 | 0: full word on the bus; 1: low half folded onto the upper lane |
| sample_in | input | 16 | Conversion result word, captured at an accepted start |
| busy | output | 1 | High while a conversion runs |
| acq | output | 1 | High while the converter is acquiring (tracking the input) |
| db_drive | output | 1 | High while `db` is actively driven |
| db | output | 16 | Tristate parallel data bus |

## Verification
`busy` is a registered state, so after a strobe that is held low it appears on the MIN_LOW-th edge counted from the first low sample. It then falls CONV_CYC edges later, and the new word is readable at the first sample where `busy` is low. `acq` lags its trigger by one edge, and after reset release it needs RST_DLY+2 edges. The bus and `db_drive` follow `cs_n`, `rd_n` and `byte_sel` with no clock at all. The bench drives every input on the falling clock edge. It counts the falling edges to the expected rising edge and samples there, and one edge before where a change must not yet have happened. Bus values are checked 1 ns after the pins are set, within the same low clock phase.

// File: rtl/sar_fe_pkg.sv
`timescale 1ns/1ps
package sar_fe_pkg;
  // Sequencer states: waiting, strobe-width qualification, conversion running.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CONV = 2'd2
  } conv_st_e;

  // Level driven on the unused lower lane in folded-byte reads.
  localparam logic FILL_BIT = 1'b1;
endpackage

// File: rtl/sar_rst_sync.sv
`timescale 1ns/1ps
module sar_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
  import sar_fe_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CONV_CYC = 153,
  parameter int MIN_LOW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_n,
  input  logic          cs_n,
  input  logic [DW-1:0] sample_in,
  output logic          busy,
  output logic [DW-1:0] result
);
  localparam int CMAX = (CONV_CYC > MIN_LOW) ? CONV_CYC : MIN_LOW;
  localparam int CW   = $clog2(CMAX + 1);

  conv_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            conv_q;
  logic            fall;
  logic            hold_en, res_en;
  logic [DW-1:0]   hold_q, res_q;

  assign fall = conv_q & ~conv_n;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hold_en = 1'b0;
    res_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (fall && !cs_n) begin
          hold_en = 1'b1;
          if (MIN_LOW <= 1) begin
            st_d  = ST_CONV;
            cnt_d = '0;
          end else begin
            st_d  = ST_ARM;
            cnt_d = CW'(1);
          end
        end
      end
      ST_ARM: begin
        if (conv_n) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (cnt_q == CW'(MIN_LOW - 1)) begin
          st_d  = ST_CONV;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_CONV: begin
        if (cnt_q == CW'(CONV_CYC - 1)) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          res_en = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      conv_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      conv_q <= conv_n;
    end
  end

  // Sample capture and output latch, each with its own enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= sample_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= hold_q;
  end

  assign busy   = (st_q == ST_CONV);
  assign result = res_q;
endmodule

// File: rtl/sar_acq_track.sv
`timescale 1ns/1ps
module sar_acq_track #(
  parameter int RST_DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic cs_n,
  output logic acq
);
  localparam int DCW = $clog2(RST_DLY + 1);

  logic [DCW-1:0] dly_q, dly_d;
  logic           done_q, done_d;
  logic           busy_q, cs_q;
  logic           acq_q, acq_d;
  logic           busy_fell, cs_fell;

  assign busy_fell = busy_q & ~busy;
  assign cs_fell   = cs_q & ~cs_n;

  always_comb begin
    dly_d  = dly_q;
    done_d = done_q;
    acq_d  = acq_q;
    if (!done_q) begin
      if (dly_q == DCW'(RST_DLY - 1)) begin
        done_d = 1'b1;
        acq_d  = 1'b1;
      end else begin
        dly_d = dly_q + DCW'(1);
      end
    end
    if (busy) begin
      acq_d = 1'b0;
    end else if (done_q && (busy_fell || cs_fell) && !cs_n) begin
      acq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
      cs_q   <= 1'b1;
      acq_q  <= 1'b0;
    end else begin
      dly_q  <= dly_d;
      done_q <= done_d;
      busy_q <= busy;
      cs_q   <= cs_n;
      acq_q  <= acq_d;
    end
  end

  assign acq = acq_q;
endmodule

// File: rtl/sar_bus_drv.sv
`timescale 1ns/1ps
module sar_bus_drv
  import sar_fe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          byte_sel,
  input  logic [DW-1:0] result,
  output logic          drive,
  output wire  [DW-1:0] db
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] word;

  assign drive = ~cs_n & ~rd_n;

  for (genvar i = 0; i < DW; i++) begin : g_lane
    if (i >= HALF) begin : g_upper
      assign word[i] = byte_sel ? result[i-HALF] : result[i];
    end else begin : g_lower
      assign word[i] = byte_sel ? FILL_BIT : result[i];
    end
    assign db[i] = drive ? word[i] : 1'bz;
  end
endmodule

// File: rtl/sar_bus_front.sv
`timescale 1ns/1ps
module sar_bus_front #(
  parameter int DW       = 16,
  parameter int CONV_CYC = 153,
  parameter int MIN_LOW  = 5,
  parameter int RST_DLY  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          byte_sel,
  input  logic [DW-1:0] sample_in,
  output logic          busy,
  output logic          acq,
  output logic          db_drive,
  output wire  [DW-1:0] db
);
  logic          rst_n_s;
  logic [DW-1:0] result;

  sar_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sar_conv_ctrl #(.DW(DW), .CONV_CYC(CONV_CYC), .MIN_LOW(MIN_LOW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .conv_n    (conv_n),
    .cs_n      (cs_n),
    .sample_in (sample_in),
    .busy      (busy),
    .result    (result)
  );

  sar_acq_track #(.RST_DLY(RST_DLY)) u_acq (
    .clk   (clk),
    .rst_n (rst_n_s),
    .busy  (busy),
    .cs_n  (cs_n),
    .acq   (acq)
  );

  sar_bus_drv #(.DW(DW)) u_bus (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .byte_sel (byte_sel),
    .result   (result),
    .drive    (db_drive),
    .db       (db)
  );
endmodule

// File: rtl/sar_bus_front_chk.sv
`timescale 1ns/1ps
module sar_bus_front_chk #(
  parameter int DW       = 16,
  parameter int CONV_CYC = 153
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_n,
  input logic          byte_sel,
  input logic          busy,
  input logic          acq,
  input logic          db_drive,
  input logic [DW-1:0] db
);
  localparam int RW   = $clog2(CONV_CYC + 2);
  localparam int HALF = DW / 2;

  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + RW'(1);
    else           run_len <= '0;
  end

  // R1
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!conv_n));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == RW'(CONV_CYC));

  // R12
  acq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !acq);

  // R12
  acq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq) |-> !busy);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!busy && !acq));

  // R6
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $stable(busy) && db_drive && $past(db_drive) && !byte_sel && $past(!byte_sel))
      |-> $stable(db));

  // R9
  fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_drive && byte_sel && $past(db_drive) && $past(!byte_sel) && !busy && $stable(busy))
      |-> db[DW-1:HALF] == $past(db[HALF-1:0]));
endmodule

bind sar_bus_front sar_bus_front_chk #(.DW(DW), .CONV_CYC(CONV_CYC)) u_chk (.*);

// File: tb/sar_bus_front_test.sv
`timescale 1ns/1ps
module sar_bus_front_test;
  localparam int DW       = 16;
  localparam int CONV_CYC = 153;
  localparam int MIN_LOW  = 5;
  localparam int RST_DLY  = 5;
  localparam int NVEC     = 6;

  // {cs low at start, sample word}
  localparam logic [16:0] VEC [NVEC] = '{
    17'h1_7FFF, 17'h1_0000, 17'h1_8000, 17'h0_1234, 17'h1_A5C3, 17'h1_00FF
  };

  logic          clk = 1'b0;
  logic          rst_n, conv_n, cs_n, rd_n, byte_sel;
  logic [DW-1:0] sample_in;
  logic          busy, acq, db_drive;
  wire  [DW-1:0] db;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  logic [DW-1:0] exp_res;
  int   lat, len;

  always #2 clk = ~clk;

  sar_bus_front #(.DW(DW), .CONV_CYC(CONV_CYC), .MIN_LOW(MIN_LOW), .RST_DLY(RST_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n),
    .byte_sel(byte_sel), .sample_in(sample_in), .busy(busy), .acq(acq),
    .db_drive(db_drive), .db(db)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic bsel, input logic [DW-1:0] exp);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; byte_sel = bsel;
    #1;
    check({tag, " data"}, 32'(db), 32'(exp));
    check("R7 driven during read", 32'(db_drive), 32'd1);
    rd_n = 1'b1;
    #1;
    check("R7 released with rd_n high", 32'(db_drive), 32'd0);
    cs_n = 1'b1; byte_sel = 1'b0;
  endtask

  task automatic do_start(input logic cs_low, input logic [DW-1:0] s, input int low_len,
                          output int lt);
    @(negedge clk);
    cs_n = ~cs_low; sample_in = s; conv_n = 1'b0; lt = -1;
    for (int k = 1; k <= low_len + 3; k++) begin
      @(negedge clk);
      if (k == 1) sample_in = ~s;
      if (k == low_len) conv_n = 1'b1;
      if (busy) begin
        lt = k;
        conv_n = 1'b1;
        break;
      end
    end
    conv_n = 1'b1;
  endtask

  task automatic wait_done(input int start, output int n);
    n = start;
    while (busy && n < CONV_CYC + 40) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (RST_DLY + 1) @(negedge clk);
    check("R11 acq still low one edge early", 32'(acq), 32'd0);
    @(negedge clk);
    check("R11 acq high after reset delay", 32'(acq), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; conv_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1; byte_sel = 1'b0;
    sample_in = '0; exp_res = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 busy low in reset", 32'(busy), 32'd0);
    check("R10 acq low in reset", 32'(acq), 32'd0);
    check("R7 idle bus not driven", 32'(db_drive), 32'd0);
    cs_n = 1'b0; #1;
    check("R7 cs low alone does not drive", 32'(db_drive), 32'd0);
    cs_n = 1'b1;
    read_chk("R10 latch cleared", 1'b0, 16'h0000);
    release_reset();

    // Table-driven conversions
    for (int v = 0; v < NVEC; v++) begin
      do_start(VEC[v][16], VEC[v][15:0], MIN_LOW, lat);
      if (VEC[v][16]) begin
        check("R1 start latency", 32'(lat), 32'(MIN_LOW));
        wait_done(1, len);
        check("R4 busy length", 32'(len), 32'(CONV_CYC));
        check("R12 acq not yet set at busy fall", 32'(acq), 32'd0);
        @(negedge clk);
        check("R12 acq one edge after busy fall", 32'(acq), 32'd1);
        exp_res = VEC[v][15:0];
      end else begin
        check("R2 cs high gives no start", 32'(lat), 32'hFFFF_FFFF);
        repeat (5) @(negedge clk);
        check("R2 busy stays low", 32'(busy), 32'd0);
      end
      read_chk("R8 R6 full word", 1'b0, exp_res);
      read_chk("R9 folded byte", 1'b1, {exp_res[7:0], 8'hFF});
    end

    // R3: strobe one sample too short
    do_start(1'b1, 16'h4321, MIN_LOW - 1, lat);
    check("R3 short strobe gives no start", 32'(lat), 32'hFFFF_FFFF);
    repeat (6) @(negedge clk);
    check("R3 busy stays low", 32'(busy), 32'd0);
    read_chk("R3 latch unchanged", 1'b0, exp_res);

    // R5: second strobe during busy is ignored
    do_start(1'b1, 16'h3C3C, MIN_LOW, lat);
    check("R1 start latency before ignore test", 32'(lat), 32'(MIN_LOW));
    repeat (20) @(negedge clk);
    sample_in = 16'hDEAD; conv_n = 1'b0;
    repeat (6) @(negedge clk);
    conv_n = 1'b1;
    wait_done(27, len);
    check("R5 busy length unchanged by second strobe", 32'(len), 32'(CONV_CYC));
    repeat (10) @(negedge clk);
    check("R5 no restart", 32'(busy), 32'd0);
    exp_res = 16'h3C3C;
    read_chk("R5 R6 original sample kept", 1'b0, exp_res);

    // R12: chip select falls after busy falls
    do_start(1'b1, 16'h0F0F, MIN_LOW, lat);
    cs_n = 1'b1;
    @(negedge clk);
    check("R12 acq low while busy", 32'(acq), 32'd0);
    wait_done(2, len);
    repeat (5) @(negedge clk);
    check("R12 acq waits for cs fall", 32'(acq), 32'd0);
    cs_n = 1'b0;
    @(negedge clk);
    check("R12 acq one edge after cs fall", 32'(acq), 32'd1);
    cs_n = 1'b1;
    exp_res = 16'h0F0F;
    read_chk("R6 later-cs result", 1'b0, exp_res);

    // R10 and R11: reset aborts a running conversion
    do_start(1'b1, 16'h5A5A, MIN_LOW, lat);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 reset aborts busy", 32'(busy), 32'd1 - 32'd1);
    check("R10 reset clears acq", 32'(acq), 32'd0);
    read_chk("R10 latch cleared by reset", 1'b0, 16'h0000);
    release_reset();
    check("R10 no busy after abort", 32'(busy), 32'd0);
    exp_res = 16'h0000;
    read_chk("R10 latch still clear", 1'b0, exp_res);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule